// File: doc/BRIEF.md
# Two-Phase Shared-Multiplier FIR Filter

This block is a direct-form FIR filter. It runs its clock at no less than twice the input sample rate, so each hardware multiplier can serve two taps. An upstream source presents a sample together with a valid strobe. At most one sample is taken every second cycle. Each accepted sample is shifted into a tap delay line.

On the first cycle after a sample is taken, 2:1 multiplexers route the even-indexed taps and coefficients to the multipliers. On the second cycle they route the odd-indexed ones. A multiplier with no odd partner gets zero on both inputs in that cycle. Each multiplier is pipelined over a fixed number of stages. The summed products of the first phase are held for one cycle and then added to the sum of the second phase. That total is the filter result, and it is flagged by its own valid pulse.

Coefficients are written through a small load port before streaming begins. If the valid strobe is raised on the cycle straight after an accepted sample, that strobe is dropped and a sticky error flag is raised. With the default five taps the filter uses three multipliers.

Top module: `fir2x_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0, `out_data` is 0 and `proto_err` is 0. Reset also clears the delay line and all coefficients to zero.
- R2: `in_valid` high in a cycle where no sample was accepted in the previous cycle accepts `in_data` into the delay line.
- R3: `in_valid` high in the cycle directly after an acceptance is ignored. It neither enters the delay line nor produces an output.
- R4: `proto_err` goes high on the cycle after an ignored strobe and stays high until reset.
- R5: Each result equals the sum over k = 0..NTAPS-1 of h(k)·x(n-k), computed as a full-precision signed value 37 bits wide. Here x(n) is the sample just accepted, x(n-k) is the sample accepted k acceptances earlier, and any x older than the first sample since reset is taken as zero.
- R6: `out_valid` pulses for exactly one cycle, five cycles after the cycle in which the sample was accepted. No pulse occurs without an acceptance.
- R7: With `coef_we` high, `coef_din` is written to coefficient h(`coef_sel`) at the clock edge. A write with `coef_sel` of NTAPS or more (5, 6 or 7) changes no coefficient.
- R8: `out_valid` is never high on two consecutive cycles, and `out_data` holds the last result until the next `out_valid` pulse.
- R9: Samples streamed before any coefficient has been loaded give results of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, at least twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 3 | Coefficient index for a write |
| coef_din | input | 18 | Signed coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 37 | Signed filter result |
| proto_err | output | 1 | Sticky flag for a strobe that came too early |

## Verification
When samples arrive on every second cycle, the delay line shifts in a new sample in the same cycle that the odd-phase multiplexers read it for the previous sample. At the output, the even-phase sum of one result is also being formed while the previous result is completed. The bench provokes this by running long stretches at the full rate, mixed with random gaps and bursts of back-to-back strobes. A behavioural model that only keeps a history of accepted samples predicts the expected value, valid flag and error flag, and these are compared with the outputs on every cycle.

// File: rtl/fir2x_pkg.sv
package fir2x_pkg;

  // number of shared multipliers: each serves an even tap and its odd neighbour
  function automatic int lane_count(input int ntaps);
    return (ntaps + 1) / 2;
  endfunction

  // full-precision result width for a sum of ntaps products
  function automatic int result_width(input int dw, input int cw, input int ntaps);
    return dw + cw + $clog2(ntaps);
  endfunction

  // index width of the coefficient load port
  function automatic int sel_width(input int ntaps);
    return (ntaps > 1) ? $clog2(ntaps) : 1;
  endfunction

endpackage

// File: rtl/fir2x_tapline.sv
module fir2x_tapline #(
  parameter int DW    = 16,
  parameter int NTAPS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic signed [DW-1:0] taps [NTAPS],
  output logic                 accept_ev,
  output logic                 dup_ev,
  output logic                 phase_even,
  output logic                 proto_err
);

  logic took_q;

  // a strobe straight after an acceptance is dropped
  assign accept_ev  = in_valid & ~took_q;
  assign dup_ev     = in_valid &  took_q;
  // delayed copy of the accept strobe steers the lane multiplexers
  assign phase_even = took_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      took_q    <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      took_q    <= accept_ev;
      proto_err <= proto_err | dup_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
    end else if (accept_ev) begin
      taps[0] <= in_data;
      for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
    end
  end

endmodule

// File: rtl/fir2x_coefbank.sv
module fir2x_coefbank #(
  parameter int CW    = 18,
  parameter int NTAPS = 5,
  parameter int SW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_we,
  input  logic [SW-1:0]        coef_sel,
  input  logic signed [CW-1:0] coef_din,
  output logic signed [CW-1:0] coefs [NTAPS]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) coefs[i] <= '0;
    end else begin
      // an index past the last tap matches no slot and is dropped
      for (int i = 0; i < NTAPS; i++)
        if (coef_we && coef_sel == SW'(i)) coefs[i] <= coef_din;
    end
  end

endmodule

// File: rtl/fir2x_lane.sv
module fir2x_lane #(
  parameter int DW  = 16,
  parameter int CW  = 18,
  parameter int LAT = 2,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_even,
  input  logic signed [DW-1:0] x_even,
  input  logic signed [CW-1:0] h_even,
  input  logic signed [DW-1:0] x_odd,
  input  logic signed [CW-1:0] h_odd,
  output logic signed [PW-1:0] prod
);

  logic signed [DW-1:0] x_mux;
  logic signed [CW-1:0] h_mux;
  logic signed [PW-1:0] pipe [LAT];

  function automatic logic signed [PW-1:0] lane_mul(
    input logic signed [DW-1:0] a, input logic signed [CW-1:0] b);
    logic signed [PW-1:0] aw, bw;
    aw = PW'(a);
    bw = PW'(b);
    return aw * bw;
  endfunction

  // 2:1 routing of sample and coefficient
  always_comb begin
    if (sel_even) begin
      x_mux = x_even;
      h_mux = h_even;
    end else begin
      x_mux = x_odd;
      h_mux = h_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= lane_mul(x_mux, h_mux);
      for (int s = 1; s < LAT; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign prod = pipe[LAT-1];

endmodule

// File: rtl/fir2x_combine.sv
module fir2x_combine #(
  parameter int PW   = 34,
  parameter int NMUL = 3,
  parameter int AW   = 37,
  parameter int LAT  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phase_even,
  input  logic signed [PW-1:0] prods [NMUL],
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);

  logic [LAT:0]         tag;
  logic signed [AW-1:0] lane_sum;
  logic signed [AW-1:0] hold_q;

  function automatic logic signed [AW-1:0] widen(input logic signed [PW-1:0] p);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  always_comb begin
    lane_sum = '0;
    for (int k = 0; k < NMUL; k++) lane_sum = lane_sum + widen(prods[k]);
  end

  // tag[LAT-1] marks the even-phase sum, tag[LAT] the odd-phase sum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag       <= '0;
      hold_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      tag[0] <= phase_even;
      for (int s = 1; s <= LAT; s++) tag[s] <= tag[s-1];
      hold_q    <= lane_sum;
      out_valid <= tag[LAT];
      if (tag[LAT]) out_data <= hold_q + lane_sum;
    end
  end

endmodule

// File: rtl/fir2x_top.sv
module fir2x_top #(
  parameter int DW       = 16,
  parameter int CW       = 18,
  parameter int NTAPS    = 5,
  parameter int MULT_LAT = 2,
  localparam int NMUL    = fir2x_pkg::lane_count(NTAPS),
  localparam int AW      = fir2x_pkg::result_width(DW, CW, NTAPS),
  localparam int SW      = fir2x_pkg::sel_width(NTAPS),
  localparam int PW      = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 coef_we,
  input  logic [SW-1:0]        coef_sel,
  input  logic signed [CW-1:0] coef_din,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data,
  output logic                 proto_err
);

  logic signed [DW-1:0] taps  [NTAPS];
  logic signed [CW-1:0] coefs [NTAPS];
  logic signed [PW-1:0] prods [NMUL];
  logic                 accept_ev;
  logic                 dup_ev;
  logic                 phase_even;

  fir2x_tapline #(.DW(DW), .NTAPS(NTAPS)) u_tapline (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .taps(taps), .accept_ev(accept_ev), .dup_ev(dup_ev),
    .phase_even(phase_even), .proto_err(proto_err)
  );

  fir2x_coefbank #(.CW(CW), .NTAPS(NTAPS), .SW(SW)) u_coefbank (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_din(coef_din), .coefs(coefs)
  );

  for (genvar k = 0; k < NMUL; k++) begin : g_lane
    logic signed [DW-1:0] x_odd;
    logic signed [CW-1:0] h_odd;
    if (2*k + 1 < NTAPS) begin : g_pair
      assign x_odd = taps[2*k+1];
      assign h_odd = coefs[2*k+1];
    end else begin : g_zero
      // no odd partner: feed zeros in the second phase
      assign x_odd = '0;
      assign h_odd = '0;
    end
    fir2x_lane #(.DW(DW), .CW(CW), .LAT(MULT_LAT)) u_lane (
      .clk(clk), .rst_n(rst_n), .sel_even(phase_even),
      .x_even(taps[2*k]), .h_even(coefs[2*k]),
      .x_odd(x_odd), .h_odd(h_odd), .prod(prods[k])
    );
  end

  fir2x_combine #(.PW(PW), .NMUL(NMUL), .AW(AW), .LAT(MULT_LAT)) u_combine (
    .clk(clk), .rst_n(rst_n), .phase_even(phase_even), .prods(prods),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/fir2x_checks.sv
module fir2x_checks (
  input logic clk,
  input logic rst_n,
  input logic accept_ev,
  input logic dup_ev,
  input logic out_valid,
  input logic proto_err
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !proto_err));

  assert_no_double_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !accept_ev);

  assert_dup_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dup_ev |=> proto_err);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // depth 5 matches the default two-stage multiplier pipeline
  assert_out_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept_ev, 5));

  assert_out_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

bind fir2x_top fir2x_checks u_checks (
  .clk(clk), .rst_n(rst_n), .accept_ev(accept_ev), .dup_ev(dup_ev),
  .out_valid(out_valid), .proto_err(proto_err)
);

// File: tb/fir2x_top_bench.sv
`timescale 1ns/1ps
module fir2x_top_bench;

  localparam int NT = 5;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic               coef_we = 1'b0;
  logic [2:0]         coef_sel = '0;
  logic signed [17:0] coef_din = '0;
  logic               out_valid;
  logic signed [36:0] out_data;
  logic               proto_err;

  fir2x_top u_fir2x_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_din(coef_din),
    .out_valid(out_valid), .out_data(out_data), .proto_err(proto_err)
  );

  always #4 clk = ~clk;

  int     total = 0;
  int     bad = 0;
  string  seg = "R9";
  longint hist [NT];
  longint h [NT];
  bit     prev_acc;
  bit     err_m;
  longint held;
  bit     qv [$];
  longint qd [$];

  task automatic check(string tag, longint act, longint exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NT; i++) begin hist[i] = 0; h[i] = 0; end
    prev_acc = 0; err_m = 0; held = 0;
    qv.delete(); qd.delete();
    for (int i = 0; i < 5; i++) begin qv.push_back(1'b0); qd.push_back(0); end
  endtask

  // one cycle: check outputs, then drive and predict this cycle's inputs
  task automatic step(bit v, int d, bit we, int sel, int cd);
    bit     ev, acc;
    longint ed, y;
    @(negedge clk);
    ev = qv.pop_front();
    ed = qd.pop_front();
    check("R6", longint'(out_valid), longint'(ev), "out_valid");
    if (ev) begin
      held = ed;
      check(seg, longint'(out_data), held, "out_data");
    end else begin
      check("R8", longint'(out_data), held, "held out_data");
    end
    check("R4", longint'(proto_err), longint'(err_m), "proto_err");
    in_valid = v; in_data = 16'(d);
    coef_we = we; coef_sel = 3'(sel); coef_din = 18'(cd);
    if (we && sel < NT) h[sel] = longint'(cd);
    acc = v && !prev_acc;
    if (v && prev_acc) err_m = 1;
    prev_acc = acc;
    if (acc) begin
      for (int i = NT-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = longint'(d);
      y = 0;
      for (int i = 0; i < NT; i++) y += h[i] * hist[i];
      qv.push_back(1'b1); qd.push_back(y);
    end else begin
      qv.push_back(1'b0); qd.push_back(0);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic send(int d, int gap);
    step(1, d, 0, 0, 0);
    idle(gap);
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst_n = 0; in_valid = 0; coef_we = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R1", longint'(out_valid), 0, "out_valid in reset");
      check("R1", longint'(out_data), 0, "out_data in reset");
      check("R1", longint'(proto_err), 0, "proto_err in reset");
    end
    rst_n = 1;
    model_clear();
  endtask

  task automatic load_coefs();
    step(0, 0, 1, 0, 3);
    step(0, 0, 1, 1, -7);
    step(0, 0, 1, 2, 11);
    step(0, 0, 1, 3, 131071);
    step(0, 0, 1, 4, -131072);
    step(0, 0, 1, 5, 999);      // R7: out-of-range index, dropped
    step(0, 0, 1, 7, -555);     // R7: out-of-range index, dropped
    idle(6);
  endtask

  initial begin
    model_clear();
    do_reset(3);

    seg = "R9";
    for (int i = 0; i < 10; i++) send(1000 + i * 37, 1);
    idle(8);

    load_coefs();
    seg = "R7";  // impulse reveals each coefficient in turn
    send(1, 1);
    for (int i = 0; i < 6; i++) send(0, 1);
    idle(6);

    seg = "R5";
    for (int i = 0; i < 80; i++)
      send(int'($signed(16'($urandom))), 1 + int'($urandom % 3));
    for (int i = 0; i < 8; i++) send(-32768, 1);
    for (int i = 0; i < 8; i++) send((i % 2) ? 32767 : -32768, 1);
    idle(6);

    seg = "R3";
    for (int i = 0; i < 9; i++) step(1, 500 * i - 2000, 0, 0, 0);
    idle(6);

    seg = "R2";
    for (int i = 0; i < 12; i++) send(int'($signed(16'($urandom))), 1);
    for (int i = 0; i < 3; i++) step(1, 77, 0, 0, 0);
    idle(2);

    do_reset(2);
    seg = "R9";
    for (int i = 0; i < 8; i++) send(-3000 + i, 1);
    idle(8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule